// File: doc/BRIEF.md
# Serial Video Word Framer

This block sits behind a high-definition serial video deserializer. The deserializer's 20-bit words arrive on the recovered clock with no known relation to the real word boundaries. The framer searches the bit stream for timing reference sequences and picks the bit offset (0 to 19) that places them on word boundaries. It then outputs aligned words: a 10-bit luma stream and a 10-bit chroma stream that travel together. If a whole line period passes without a timing reference at the current offset, the offset moves by one bit and the search starts again.

From the decoded timing references and line-number words, the block drives three strobes that line up with the output words. One marks the line-number word. One marks the first line of a frame. One covers the horizontal blanking interval. These strobes, the data-valid output and the framing logic only run while the receive-mode input is high.

Top module: `vid_word_framer`

## Requirements
- R1: After the clock edge that accepts input word n, the output word holds 20 consecutive received bits. They start at bit k of input word n-5 and run on into word n-4, where k is the current slip offset. Bit 0 of each input word is the earliest received bit. Luma is output bits 19:10 and chroma is bits 9:0.
- R2: out_valid is high for one cycle after each edge that accepts a word (in_valid and rx_mode both high), and low after any other edge.
- R3: A timing reference is four aligned words whose two 10-bit halves are equal: 3FF, 000, 000, then a status word. The status word must have bit 9 set and bits 1:0 clear. If it does not, the sequence is ignored and produces no strobes. Bit 6 of the status word set means end of line; clear means start of active video.
- R4: After reset the slip offset is 0. Each run of LINE_WORDS+MARGIN accepted words with no timing reference moves the offset up by one, and 19 wraps to 0. So a stream whose true offset is p is not aligned before p such runs have passed.
- R5: aligned_o rises when a timing reference is found at the current offset. It stays high while references keep arriving within LINE_WORDS+MARGIN accepted words, so one missing reference does not drop it. It falls when that window runs out.
- R6: line_o is high with the second word after an end-of-line status word (the word that carries the high line-number bits), and with no other word.
- R7: frame_o is high with that same word only when the decoded 11-bit line number equals 1. Line-number bits 6:0 come from bits 8:2 of the first word's luma, and bits 10:7 come from bits 5:2 of the second word's luma.
- R8: hanc_o is high for every word after the fourth word that follows an end-of-line status word, up to the last word before the next 3FF. It is low for reference words, line-number words, check words and active video.
- R9: While rx_mode is low, input words are not accepted. From the next cycle, out_valid, line_o, frame_o and hanc_o are low, and the alignment state is kept.
- R10: Reset clears every output to zero.
- R11: A stream with no timing reference never raises aligned_o, line_o, frame_o or hanc_o, even across a full wrap of the slip offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | High selects receive operation; enables framing |
| in_valid | input | 1 | in_word carries a new deserialized word |
| in_word | input | 20 | Unaligned word, bit 0 received first |
| out_valid | output | 1 | Output word and strobes updated this cycle |
| out_luma | output | 10 | Aligned luma word |
| out_chroma | output | 10 | Aligned chroma word |
| line_o | output | 1 | Line-number word strobe |
| frame_o | output | 1 | First-line-of-frame strobe |
| hanc_o | output | 1 | Horizontal blanking interval |
| aligned_o | output | 1 | A timing reference was found at the current offset |

## Verification
The streams are built from synthetic lines. Each line has an end reference, line numbers, check words, blanking, a start reference and active video, and the whole stream is shifted by a chosen bit phase. A phase of 5 starting from reset measures the one-bit-per-period slip. Switching the phase from 5 to 2 forces the offset to wrap past 19, and the bench checks both when lock is lost and when it is regained. Line numbers 1125 and 1 are both used, so the frame strobe depends on the full 11-bit decode. Other tests use a removed 3FF, an illegal status word, a stream with no references at all, and a pause of receive mode. These separate "lock held through one gap" from "lock dropped", and "marker rejected" from "strobes gated by mode".

// File: rtl/vid_word_framer.sv
module vid_word_framer #(
  parameter int LINE_WORDS = 2200,
  parameter int MARGIN     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_mode,
  input  logic        in_valid,
  input  logic [19:0] in_word,
  output logic        out_valid,
  output logic [9:0]  out_luma,
  output logic [9:0]  out_chroma,
  output logic        line_o,
  output logic        frame_o,
  output logic        hanc_o,
  output logic        aligned_o
);
  localparam int WW      = 20;
  localparam int HW      = WW / 2;
  localparam int DEPTH   = 4;
  localparam int TIMEOUT = LINE_WORDS + MARGIN;
  localparam int TW      = $clog2(TIMEOUT + 1);
  localparam int OW      = $clog2(WW);
  localparam logic [OW-1:0] OFF_LAST = OW'(WW - 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT - 1);

  typedef enum logic [3:0] {
    R_IDLE, R_T0, R_T1, R_T2, R_T3, R_LN0, R_LN1, R_C0, R_C1, R_BLK, R_ACT
  } role_t;

  logic [WW-1:0]   prev_q;
  logic [WW-1:0]   pipe_q [DEPTH];
  logic [OW-1:0]   off_q;
  logic [TW-1:0]   tmr_q;
  role_t           role_q, role_n;
  logic            eav_q;
  logic [6:0]      ln0_q;
  logic            adv, trs_hit, expired, is_end;
  logic [2*WW-1:0] win;
  logic [WW-1:0]   slice;
  logic [10:0]     lnum;

  function automatic logic pair_is(input logic [WW-1:0] w, input logic [HW-1:0] v);
    return (w[WW-1:HW] == v) && (w[HW-1:0] == v);
  endfunction

  function automatic logic xyz_legal(input logic [WW-1:0] w);
    return (w[WW-1:HW] == w[HW-1:0]) && w[HW-1] && (w[1:0] == 2'b00);
  endfunction

  assign adv     = in_valid && rx_mode;
  assign win     = {in_word, prev_q};
  assign slice   = win[off_q +: WW];
  assign trs_hit = pair_is(pipe_q[DEPTH-1], 10'h3FF) && pair_is(pipe_q[DEPTH-2], 10'h000) &&
                   pair_is(pipe_q[DEPTH-3], 10'h000) && xyz_legal(pipe_q[0]);
  assign is_end  = pipe_q[0][HW+6];
  assign expired = (tmr_q == TMR_LAST) && !trs_hit;
  assign lnum    = {pipe_q[DEPTH-1][HW+5:HW+2], ln0_q};

  always_comb begin
    role_n = role_q;
    if (expired) role_n = R_IDLE;
    else if (trs_hit) role_n = R_T0;
    else begin
      case (role_q)
        R_T0:    role_n = R_T1;
        R_T1:    role_n = R_T2;
        R_T2:    role_n = R_T3;
        R_T3:    role_n = eav_q ? R_LN0 : R_ACT;
        R_LN0:   role_n = R_LN1;
        R_LN1:   role_n = R_C0;
        R_C0:    role_n = R_C1;
        R_C1:    role_n = R_BLK;
        R_BLK:   role_n = R_BLK;
        R_ACT:   role_n = R_ACT;
        default: role_n = R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= '0;
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
      off_q      <= '0;
      tmr_q      <= '0;
      role_q     <= R_IDLE;
      eav_q      <= 1'b0;
      ln0_q      <= '0;
      out_valid  <= 1'b0;
      out_luma   <= '0;
      out_chroma <= '0;
      line_o     <= 1'b0;
      frame_o    <= 1'b0;
      hanc_o     <= 1'b0;
      aligned_o  <= 1'b0;
    end else begin
      out_valid <= adv;
      if (adv) begin
        prev_q    <= in_word;
        pipe_q[0] <= slice;
        for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
        out_luma   <= pipe_q[DEPTH-1][WW-1:HW];
        out_chroma <= pipe_q[DEPTH-1][HW-1:0];
        role_q     <= role_n;
        line_o     <= (role_n == R_LN1);
        frame_o    <= (role_n == R_LN1) && (lnum == 11'd1);
        hanc_o     <= (role_n == R_BLK);
        if (role_n == R_LN0) ln0_q <= pipe_q[DEPTH-1][HW+8:HW+2];
        if (trs_hit) begin
          eav_q     <= is_end;
          tmr_q     <= '0;
          aligned_o <= 1'b1;
        end else if (expired) begin
          tmr_q     <= '0;
          aligned_o <= 1'b0;
          off_q     <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end else if (!rx_mode) begin
        line_o  <= 1'b0;
        frame_o <= 1'b0;
        hanc_o  <= 1'b0;
      end
    end
  end

  a_r4_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OFF_LAST);

  a_r4_slip_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(off_q) |-> !aligned_o);

  a_r5_lock_from_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_o) |-> $past(trs_hit && adv));

  a_r6_line_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    line_o |=> !(line_o && out_valid));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |=> (!out_valid && !line_o && !frame_o && !hanc_o));
endmodule

// File: tb/vid_word_framer_bench.sv
module vid_word_framer_bench;
  localparam int LW = 40;
  localparam int MG = 8;
  localparam int TO = LW + MG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_mode = 1'b1;
  logic        in_valid = 1'b0;
  logic [19:0] in_word = '0;
  logic        out_valid, line_o, frame_o, hanc_o, aligned_o;
  logic [9:0]  out_luma, out_chroma;

  vid_word_framer #(.LINE_WORDS(LW), .MARGIN(MG)) u_vid_word_framer (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_luma(out_luma), .out_chroma(out_chroma),
    .line_o(line_o), .frame_o(frame_o), .hanc_o(hanc_o), .aligned_o(aligned_o));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int k = 0, phase = 0, loff = 0;
  int bad_line = -1, miss_line = -1;
  bit plain = 0;
  logic [19:0] prev_v = '0;
  int frames_seen = 0, lines_in_bad = 0;

  function automatic logic [10:0] lnum_of(int line);
    return 11'(((line + loff) % 1125) + 1);
  endfunction

  function automatic logic [19:0] vword(int m);
    int line = m / LW;
    int pos = m % LW;
    logic [10:0] L = lnum_of(line);
    logic [9:0] y, c;
    if (plain) return {10'h1AC, 10'h0C8};
    case (pos)
      0:  begin y = (line == miss_line) ? 10'h1AC : 10'h3FF; c = y; end
      1, 2, 17, 18: begin y = 10'h000; c = 10'h000; end
      3:  begin y = (line == bad_line) ? 10'h040 : 10'h240; c = y; end
      4:  begin y = {~L[6], L[6:0], 2'b00}; c = y; end
      5:  begin y = {1'b1, 3'b000, L[10:7], 2'b00}; c = y; end
      6:  begin y = 10'h155; c = 10'h2AA; end
      7:  begin y = 10'h2AA; c = 10'h155; end
      16: begin y = 10'h3FF; c = 10'h3FF; end
      19: begin y = 10'h200; c = 10'h200; end
      default: begin
        if (pos < 16) begin y = 10'h1AC; c = 10'h0C8; end
        else begin y = 10'h100 + 10'(pos); c = 10'h180 + 10'(pos); end
      end
    endcase
    return {y, c};
  endfunction

  task automatic ck(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit chk);
    logic [19:0] vv = '0;
    int idx, line, pos;
    bit eok, el, ef, eh;
    logic [19:0] e;
    if (v) begin
      vv = vword(k);
      in_word = 20'({vv, prev_v} >> (20 - phase));
      in_valid = 1'b1;
    end else in_valid = 1'b0;
    @(posedge clk); #1;
    if (v) begin prev_v = vv; k++; end
    if (chk) begin
      if (!v) ck(out_valid == 1'b0, "R2", "out_valid idle", out_valid, 0);
      else begin
        idx = k - 1 - 5;
        line = idx / LW; pos = idx % LW;
        e = vword(idx);
        eok = !plain && line != bad_line && line != miss_line;
        el = eok && pos == 5;
        ef = el && lnum_of(line) == 11'd1;
        eh = eok && pos >= 8 && pos <= 15;
        if (frame_o) frames_seen++;
        if (line_o && line == bad_line) lines_in_bad++;
        ck(out_valid == 1'b1, "R2", "out_valid", out_valid, 1);
        ck({out_luma, out_chroma} == e, "R1", "word", {out_luma, out_chroma}, e);
        ck(line_o == el, "R6", "line_o", line_o, el);
        ck(frame_o == ef, "R7", "frame_o", frame_o, ef);
        ck(hanc_o == eh, "R8", "hanc_o", hanc_o, eh);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    ck(out_valid == 0 && line_o == 0 && frame_o == 0 && hanc_o == 0, "R10", "strobes", {out_valid, line_o, frame_o, hanc_o}, 0);
    ck(out_luma == 0 && out_chroma == 0, "R10", "data", {out_luma, out_chroma}, 0);
    ck(aligned_o == 0, "R10", "aligned", aligned_o, 0);
  endtask

  task automatic t_no_marker();
    plain = 1;
    do_reset();
    repeat (22 * TO) begin
      step(1, 0);
      ck(aligned_o == 0, "R11", "aligned", aligned_o, 0);
      ck(!(line_o || frame_o || hanc_o), "R11", "strobes", {line_o, frame_o, hanc_o}, 0);
    end
    plain = 0;
  endtask

  task automatic t_lock();
    int first = -1;
    int chk_from, cyc;
    phase = 5;
    do_reset();
    for (int s = 1; s <= (phase + 2) * TO; s++) begin
      step(1, 0);
      if (aligned_o && first < 0) first = s;
    end
    ck(first > phase * TO && first <= (phase + 1) * TO, "R4", "lock step", first, (phase + 1) * TO);
    ck(aligned_o == 1, "R5", "aligned after search", aligned_o, 1);
    chk_from = k + 2 * LW;
    loff = 1125 - ((chk_from / LW + 2) % 1125);
    frames_seen = 0;
    cyc = 0;
    while (k < chk_from + 4 * LW) begin
      cyc++;
      step(cyc % 7 != 0, k >= chk_from);
    end
    ck(frames_seen == 1, "R7", "frame count", frames_seen, 1);
  endtask

  task automatic t_missing();
    int stop_k;
    miss_line = k / LW + 2;
    stop_k = (miss_line + 2) * LW;
    while (k < stop_k) begin
      step(1, 1);
      ck(aligned_o == 1, "R5", "aligned through gap", aligned_o, 1);
    end
    miss_line = -1;
  endtask

  task automatic t_bad_xyz();
    int stop_k;
    bad_line = k / LW + 2;
    stop_k = (bad_line + 2) * LW;
    lines_in_bad = 0;
    while (k < stop_k) step(1, 1);
    ck(lines_in_bad == 0, "R3", "line strobes on illegal status word", lines_in_bad, 0);
    bad_line = -1;
  endtask

  task automatic t_mode_off();
    int chk_from;
    rx_mode = 1'b0;
    repeat (60) begin
      step(1, 0);
      ck(!out_valid && !line_o && !frame_o && !hanc_o, "R9", "outputs while off",
         {out_valid, line_o, frame_o, hanc_o}, 0);
    end
    ck(aligned_o == 1, "R9", "alignment kept", aligned_o, 1);
    rx_mode = 1'b1;
    chk_from = (k / LW + 2) * LW;
    while (k < chk_from + 2 * LW) step(1, k >= chk_from);
    ck(aligned_o == 1, "R9", "aligned after resume", aligned_o, 1);
  endtask

  task automatic t_relock();
    int s = 0, fell_at = -1, chk_from;
    phase = 2;
    while (!(fell_at > 0 && aligned_o) && s < 25 * TO) begin
      step(1, 0);
      s++;
      if (!aligned_o && fell_at < 0) fell_at = s;
    end
    ck(fell_at >= TO - LW / 2 - 1 && fell_at <= TO + 3, "R5", "drop step", fell_at, TO);
    ck(aligned_o == 1, "R4", "relock after wrap", aligned_o, 1);
    ck(s > 16 * TO, "R4", "slips from 5 to 2", s, 17 * TO);
    chk_from = (k / LW + 2) * LW;
    while (k < chk_from + 2 * LW) step(1, k >= chk_from);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_no_marker();
    t_lock();
    t_missing();
    t_bad_xyz();
    t_mode_off();
    t_relock();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule